// File: doc/BRIEF.md
# SDR SDRAM Command Sequencer

This block sits between a simple host request port and a single-data-rate SDRAM with four banks and shared row/column address pins. After reset it waits a settle period and then puts the memory into a known state. It closes every open row, runs a set of refresh cycles and loads the mode register. Only then does it raise `ready_o`. From then on each accepted host request becomes a short fixed sequence: the row is opened, one column command with auto-precharge follows, and the controller waits long enough for the bank to be idle again.

Every access is one word long (burst length 1, sequential order). All delays are parameters that count clocks. Each one is the nanosecond minimum divided by the clock period and rounded up. A free-running interval timer raises a refresh request. The request is held until the controller is idle, and it is served before any further host request is taken. Read data is captured from the split input bus CAS-latency clocks after the read command reaches the memory, and it is returned on `rvalid_o`/`rdata_o`.

Top module: `sdram_seq_ctrl`

## Requirements
- R1: While `rst_ni` is low, `cke_o` is 0, `ready_o` is 0, `dqm_o` is all ones and the command is NOP. After release, only NOP is issued for `T_INIT` clocks.
- R2: The power-up sequence is as follows. PRECHARGE with A10=1 appears in the `T_INIT`-th cycle after reset release. `INIT_REFS` AUTO-REFRESH commands follow it. Then MODE REGISTER SET loads A[2:0]=000 (one word), A3=0 (sequential) and A[6:4]=`CAS_LAT`, with all other bits 0. Any later command is at least 2 clocks after it. `ready_o` never rises before the MRS.
- R3: Commands on {cs_n, ras_n, cas_n, we_n} use these codes: MRS 0000, REFRESH 0001, PRECHARGE 0010, ACTIVATE 0011, WRITE 0100, READ 0101, NOP 0111. No other code is ever driven.
- R4: `addr_i` is {bank[1:0], row[12:0], col[9:0]}. ACTIVATE drives BA=bank and A=row. READ and WRITE drive BA=bank, A[9:0]=col, A10=1 (auto-precharge) and A[12:11]=0.
- R5: The column command follows its ACTIVATE after exactly `T_RCD` clocks.
- R6: Two ACTIVATEs are at least `T_RC` clocks apart. An ACTIVATE comes at least 2+`T_RP` clocks after the previous WRITE.
- R7: Refresh is requested every `T_REFI` clocks. It is held pending and served from idle before the next request is accepted. The gap between refreshes stays within `T_REFI`+`T_RCD`+recovery+3. No ACTIVATE starts more than `T_REFI`+2 clocks after the last refresh. No command follows a refresh within `T_RC` clocks.
- R8: In the WRITE cycle, `dq_oe_o`=1, `dq_o` is the request's write data and `dqm_o`=~`be_i`. In every other cycle `dq_oe_o`=0.
- R9: `dq_i` is sampled on the edge `CAS_LAT`+1 clocks after the edge that issues READ. `rvalid_o` pulses for one cycle with that word on `rdata_o`.
- R10: A request is accepted on an edge where `req_i` and `ready_o` are both high. In the next cycle `ready_o` is 0 and ACTIVATE is on the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 25 | {bank, row, column} |
| wdata_i | input | 16 | Write data |
| be_i | input | 2 | Byte enables for a write |
| ready_o | output | 1 | Request can be accepted |
| rvalid_o | output | 1 | Read data valid pulse |
| rdata_o | output | 16 | Read data |
| cke_o | output | 1 | Clock enable to memory |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | 2 | Bank select |
| a_o | output | 13 | Multiplexed address |
| dqm_o | output | 2 | Data mask per byte |
| dq_o | output | 16 | Write data to memory |
| dq_oe_o | output | 1 | Write data drive enable |
| dq_i | input | 16 | Read data from memory |

## Verification
The bench drives the controller with a behavioural memory and a host-level word store. It covers several patterns. Full-mask writes at the extreme bank, row and column corners confirm the address split. Single-byte writes that merge into one word show that the mask reaches the right lane. A read of an address never written checks capture timing against a known filler value on the bus. Back-to-back mixed traffic, held long enough to span several refresh intervals, separates a controller that serves a pending refresh from one that starves it. The same traffic also shows whether recovery waits hold after writes as well as after reads.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } sdr_cmd_e;

  typedef enum logic [2:0] {
    ST_SETTLE, ST_IREF, ST_MRS, ST_IDLE, ST_COL
  } seq_state_e;

  function automatic int imax(input int x, input int y);
    return (x > y) ? x : y;
  endfunction
endpackage

// File: rtl/sdr_ref_timer.sv
module sdr_ref_timer #(
  parameter int T_REFI = 780
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int W = $clog2(T_REFI);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= W'(T_REFI - 1);
      tick_o <= 1'b0;
    end else if (cnt_q == '0) begin
      cnt_q  <= W'(T_REFI - 1);
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q - 1'b1;
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sdr_rd_pipe.sv
module sdr_rd_pipe #(
  parameter int CAS_LAT = 3,
  parameter int DW      = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          issue_i,
  input  logic [DW-1:0] dq_i,
  output logic          rvalid_o,
  output logic [DW-1:0] rdata_o
);
  // bit k set: read command left the controller k+1 edges ago
  logic [CAS_LAT:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q     <= '0;
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      sr_q     <= {sr_q[CAS_LAT-1:0], issue_i};
      rvalid_o <= sr_q[CAS_LAT];
      if (sr_q[CAS_LAT]) rdata_o <= dq_i;
    end
  end
endmodule

// File: rtl/sdram_seq_ctrl.sv
module sdram_seq_ctrl
  import sdram_seq_pkg::*;
#(
  parameter int T_INIT    = 20,
  parameter int T_RP      = 2,
  parameter int T_RCD     = 2,
  parameter int T_RAS     = 5,
  parameter int T_RC      = 7,
  parameter int T_REFI    = 780,
  parameter int CAS_LAT   = 3,
  parameter int INIT_REFS = 2,
  parameter int DW        = 16,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 10,
  parameter int BANK_W    = 2,
  localparam int BEW      = DW / 8,
  localparam int AW       = BANK_W + ROW_W + COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [BEW-1:0]    be_i,
  output logic              ready_o,
  output logic              rvalid_o,
  output logic [DW-1:0]     rdata_o,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BANK_W-1:0] ba_o,
  output logic [ROW_W-1:0]  a_o,
  output logic [BEW-1:0]    dqm_o,
  output logic [DW-1:0]     dq_o,
  output logic              dq_oe_o,
  input  logic [DW-1:0]     dq_i
);
  localparam int T_WR   = 2;
  localparam int T_MRD  = 2;
  localparam int K_RC   = T_RC - T_RCD;
  localparam int K_AS   = T_RAS - T_RCD + T_RP;
  localparam int K_WR   = imax(imax(T_WR + T_RP, K_RC), K_AS);
  localparam int K_RD   = imax(imax(T_RP + 1, K_RC), imax(K_AS, CAS_LAT + 1));
  localparam int MAXD   = imax(imax(T_INIT, T_RC), imax(K_WR, K_RD));
  localparam int CNT_W  = $clog2(MAXD + 1);
  localparam int REFS_W = $clog2(INIT_REFS + 1);
  localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'(CAS_LAT << 4);

  seq_state_e         state_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [REFS_W-1:0]  refs_q;
  sdr_cmd_e           cmd_q;
  logic [BANK_W-1:0]  ba_q;
  logic [ROW_W-1:0]   a_q;
  logic [BEW-1:0]     dqm_q;
  logic [DW-1:0]      dq_q;
  logic               oe_q, cke_q, ref_pend_q;
  logic               acc_we_q;
  logic [AW-1:0]      acc_addr_q;
  logic [DW-1:0]      acc_data_q;
  logic [BEW-1:0]     acc_be_q;
  logic               ref_tick, col_go, rd_issue;

  sdr_ref_timer #(.T_REFI(T_REFI)) i_ref_timer (
    .clk_i, .rst_ni, .tick_o(ref_tick)
  );

  assign col_go   = (state_q == ST_COL) && (cnt_q == '0);
  assign rd_issue = col_go && !acc_we_q;
  assign ready_o  = (state_q == ST_IDLE) && (cnt_q == '0) && !ref_pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_SETTLE;
      cnt_q      <= CNT_W'(T_INIT - 1);
      refs_q     <= REFS_W'(INIT_REFS);
      cmd_q      <= CMD_NOP;
      ba_q       <= '0;
      a_q        <= '0;
      dqm_q      <= '1;
      dq_q       <= '0;
      oe_q       <= 1'b0;
      cke_q      <= 1'b0;
      ref_pend_q <= 1'b0;
      acc_we_q   <= 1'b0;
      acc_addr_q <= '0;
      acc_data_q <= '0;
      acc_be_q   <= '0;
    end else begin
      cke_q <= 1'b1;
      cmd_q <= CMD_NOP;
      oe_q  <= 1'b0;
      dqm_q <= '0;
      if (ref_tick) ref_pend_q <= 1'b1;
      if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end else begin
        unique case (state_q)
          ST_SETTLE: begin
            cmd_q   <= CMD_PRE;
            a_q     <= '0;
            a_q[10] <= 1'b1;
            cnt_q   <= CNT_W'(T_RP - 1);
            state_q <= ST_IREF;
          end
          ST_IREF: begin
            cmd_q  <= CMD_REF;
            cnt_q  <= CNT_W'(T_RC - 1);
            refs_q <= refs_q - 1'b1;
            if (refs_q == REFS_W'(1)) state_q <= ST_MRS;
          end
          ST_MRS: begin
            cmd_q   <= CMD_MRS;
            a_q     <= MODE_WORD;
            ba_q    <= '0;
            cnt_q   <= CNT_W'(T_MRD - 1);
            state_q <= ST_IDLE;
          end
          ST_IDLE: begin
            if (ref_pend_q) begin
              cmd_q      <= CMD_REF;
              cnt_q      <= CNT_W'(T_RC - 1);
              ref_pend_q <= ref_tick;
            end else if (req_i) begin
              cmd_q      <= CMD_ACT;
              ba_q       <= addr_i[AW-1 -: BANK_W];
              a_q        <= addr_i[COL_W +: ROW_W];
              acc_we_q   <= we_i;
              acc_addr_q <= addr_i;
              acc_data_q <= wdata_i;
              acc_be_q   <= be_i;
              cnt_q      <= CNT_W'(T_RCD - 1);
              state_q    <= ST_COL;
            end
          end
          ST_COL: begin
            a_q                <= '0;
            a_q[COL_W-1:0]     <= acc_addr_q[COL_W-1:0];
            a_q[10]            <= 1'b1;
            ba_q               <= acc_addr_q[AW-1 -: BANK_W];
            state_q            <= ST_IDLE;
            if (acc_we_q) begin
              cmd_q <= CMD_WR;
              dq_q  <= acc_data_q;
              oe_q  <= 1'b1;
              dqm_q <= ~acc_be_q;
              cnt_q <= CNT_W'(K_WR - 1);
            end else begin
              cmd_q <= CMD_RD;
              cnt_q <= CNT_W'(K_RD - 1);
            end
          end
          default: state_q <= ST_SETTLE;
        endcase
      end
    end
  end

  sdr_rd_pipe #(.CAS_LAT(CAS_LAT), .DW(DW)) i_rd_pipe (
    .clk_i, .rst_ni, .issue_i(rd_issue), .dq_i,
    .rvalid_o, .rdata_o
  );

  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd_q;
  assign cke_o   = cke_q;
  assign ba_o    = ba_q;
  assign a_o     = a_q;
  assign dqm_o   = dqm_q;
  assign dq_o    = dq_q;
  assign dq_oe_o = oe_q;
endmodule

// File: rtl/sdram_seq_chk.sv
module sdram_seq_chk
  import sdram_seq_pkg::*;
#(
  parameter int T_RCD = 2,
  parameter int T_RC  = 7
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic        ready_o,
  input logic        cs_n_o,
  input logic        ras_n_o,
  input logic        cas_n_o,
  input logic        we_n_o,
  input logic [12:0] a_o
);
  logic [3:0] cmd;
  logic       is_act, is_col, is_mrs, is_nop;
  logic [7:0] since_act_q;
  logic       mrs_seen_q;

  assign cmd    = {cs_n_o, ras_n_o, cas_n_o, we_n_o};
  assign is_act = (cmd == CMD_ACT);
  assign is_col = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign is_mrs = (cmd == CMD_MRS);
  assign is_nop = (cmd == CMD_NOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_act_q <= 8'hff;
      mrs_seen_q  <= 1'b0;
    end else begin
      if (is_act) since_act_q <= 8'd1;
      else if (since_act_q != 8'hff) since_act_q <= since_act_q + 8'd1;
      if (is_mrs) mrs_seen_q <= 1'b1;
    end
  end

  assert_act_to_col_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_col |-> (since_act_q == 8'(T_RCD)));
  assert_act_spacing_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_act |-> (since_act_q >= 8'(T_RC)));
  assert_autopre_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_col |-> a_o[10]);
  assert_mrs_gap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_mrs |=> is_nop);
  assert_ready_after_mrs_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (mrs_seen_q || is_mrs));
  assert_accept_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o) |=> (!ready_o && is_act));
endmodule

bind sdram_seq_ctrl sdram_seq_chk #(.T_RCD(T_RCD), .T_RC(T_RC)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .ready_o(ready_o),
  .cs_n_o(cs_n_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o),
  .a_o(a_o)
);

// File: tb/test_sdram_seq_ctrl.sv
`timescale 1ns/1ps
module test_sdram_seq_ctrl;
  localparam int T_INIT = 20, T_RP = 2, T_RCD = 2, T_RAS = 5, T_RC = 7;
  localparam int T_REFI = 780, CL = 3, INIT_REFS = 2;
  localparam int KMAX = 5;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [24:0] addr = '0;
  logic [15:0] wdata = '0, dq_i = 16'hdead;
  logic [1:0]  be = '0;
  logic ready_o, rvalid_o, cke_o, cs_n_o, ras_n_o, cas_n_o, we_n_o, dq_oe_o;
  logic [15:0] rdata_o, dq_o;
  logic [1:0]  ba_o, dqm_o;
  logic [12:0] a_o;

  always #5 clk = ~clk;

  sdram_seq_ctrl #(.T_INIT(T_INIT), .T_RP(T_RP), .T_RCD(T_RCD), .T_RAS(T_RAS),
    .T_RC(T_RC), .T_REFI(T_REFI), .CAS_LAT(CL), .INIT_REFS(INIT_REFS)) i_sdram_seq_ctrl (
    .clk_i(clk), .rst_ni, .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .be_i(be), .ready_o, .rvalid_o, .rdata_o, .cke_o, .cs_n_o, .ras_n_o, .cas_n_o,
    .we_n_o, .ba_o, .a_o, .dqm_o, .dq_o, .dq_oe_o, .dq_i);

  int checks = 0, failures = 0;

  task automatic chk(input bit ok, input string req_tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req_tag, what, act, exp);
    end
  endtask

  typedef struct {bit w; int bank; int row; int col; logic [15:0] d; logic [1:0] be;} acc_t;
  acc_t        exp_q[$];
  logic [15:0] rd_exp[$];
  logic [15:0] hmem[int];
  logic [15:0] bmem[int];

  // ---------------- pin-level reference model ----------------
  int cyc = 0, rel_cyc = -1;
  bit prev_rst = 0, pre_seen = 0, mrs_seen = 0, ready_seen = 0, exp_rv = 0;
  int init_refs = 0, mrs_cyc = 0, nref = 0;
  int last_act = -1000, last_wr = -1000, last_ref = -1000;
  int rd_cd = 0;
  logic [15:0] rd_val = '0;
  int act_row[4];

  always @(negedge clk) begin
    logic [3:0] c;
    bit nxt_rv;
    acc_t e;
    int key;
    cyc++;
    if (!rst_ni) begin
      prev_rst = 0;
    end else begin
      if (!prev_rst) rel_cyc = cyc;
      prev_rst = 1;
      c = {cs_n_o, ras_n_o, cas_n_o, we_n_o};
      // R9 read return
      if (exp_rv) begin
        chk(rvalid_o === 1'b1, "R9", "rvalid missing", 32'(rvalid_o), 1);
        if (rd_exp.size() > 0) begin
          chk(rdata_o === rd_exp[0], "R9", "read data", 32'(rdata_o), 32'(rd_exp[0]));
          void'(rd_exp.pop_front());
        end else chk(0, "R9", "no read expected", 0, 1);
      end else if (rvalid_o) chk(0, "R9", "spurious rvalid", 1, 0);
      nxt_rv = 0;
      dq_i = 16'hdead;
      if (rd_cd > 0) begin
        rd_cd--;
        if (rd_cd == 0) begin dq_i = rd_val; nxt_rv = 1; end
      end
      exp_rv = nxt_rv;
      // R8 bus enable outside writes
      if (c != 4'b0100) chk(dq_oe_o === 1'b0, "R8", "oe outside write", 32'(dq_oe_o), 0);
      if (ready_o && !ready_seen) begin
        ready_seen = 1;
        chk(mrs_seen && cyc >= mrs_cyc + 1, "R2", "ready before setup", 32'(cyc), 32'(mrs_cyc + 1));
      end
      if (c != 4'b0111) begin
        chk(c inside {4'b0000, 4'b0001, 4'b0010, 4'b0011, 4'b0100, 4'b0101}, "R3", "illegal code", 32'(c), 0);
        chk(cyc >= rel_cyc + T_INIT - 1, "R1", "command during settle", 32'(cyc), 32'(rel_cyc + T_INIT - 1));
        if (mrs_seen) chk(cyc >= mrs_cyc + 2, "R2", "command too soon after MRS", 32'(cyc), 32'(mrs_cyc + 2));
        if (c != 4'b0100 && c != 4'b0101 && c != 4'b0010)
          chk(cyc - last_ref >= T_RC, "R7", "command too soon after refresh", 32'(cyc - last_ref), T_RC);
      end
      case (c)
        4'b0010: begin
          chk(!pre_seen && !mrs_seen && cyc == rel_cyc + T_INIT - 1, "R2", "precharge-all timing", 32'(cyc), 32'(rel_cyc + T_INIT - 1));
          chk(a_o[10] === 1'b1, "R2", "precharge A10", 32'(a_o), 32'h400);
          pre_seen = 1;
        end
        4'b0001: begin
          if (!mrs_seen) begin
            chk(pre_seen, "R2", "refresh before precharge", 0, 1);
            init_refs++;
          end else begin
            nref++;
            chk(cyc - last_ref <= T_REFI + T_RCD + KMAX + 3, "R7", "refresh gap", 32'(cyc - last_ref), T_REFI + T_RCD + KMAX + 3);
          end
          last_ref = cyc;
        end
        4'b0000: begin
          chk(init_refs == INIT_REFS, "R2", "init refresh count", 32'(init_refs), INIT_REFS);
          chk(a_o === 13'(CL << 4) && ba_o === 2'b00, "R2", "mode word", 32'(a_o), 32'(CL << 4));
          mrs_seen = 1; mrs_cyc = cyc;
        end
        4'b0011: begin
          chk(cyc - last_act >= T_RC, "R6", "act spacing", 32'(cyc - last_act), T_RC);
          chk(cyc - last_wr >= 2 + T_RP, "R6", "write recovery", 32'(cyc - last_wr), 2 + T_RP);
          chk(cyc - last_ref <= T_REFI + 2, "R7", "access while refresh overdue", 32'(cyc - last_ref), T_REFI + 2);
          if (exp_q.size() > 0) begin
            e = exp_q[0];
            chk(ba_o === 2'(e.bank) && a_o === 13'(e.row), "R4", "act bank/row", {17'd0, ba_o, a_o}, 32'({e.bank[1:0], e.row[12:0]}));
          end else chk(0, "R4", "unexpected act", 0, 1);
          act_row[ba_o] = int'(a_o);
          last_act = cyc;
        end
        4'b0100, 4'b0101: begin
          chk(cyc - last_act == T_RCD, "R5", "act to column", 32'(cyc - last_act), T_RCD);
          if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            chk(a_o[9:0] === 10'(e.col) && a_o[10] === 1'b1 && a_o[12:11] === 2'b00 && ba_o === 2'(e.bank),
                "R4", "column address", {17'd0, ba_o, a_o}, 32'({e.bank[1:0], 3'b001, e.col[9:0]}));
            chk(e.w == (c == 4'b0100), "R4", "column kind", 32'(c), 32'(e.w));
            key = (int'(ba_o) << 23) | (act_row[ba_o] << 10) | int'(a_o[9:0]);
            if (c == 4'b0100) begin
              chk(dq_oe_o === 1'b1 && dq_o === e.d, "R8", "write data", 32'(dq_o), 32'(e.d));
              chk(dqm_o === ~e.be, "R8", "write mask", 32'(dqm_o), 32'(~e.be));
              if (!bmem.exists(key)) bmem[key] = '0;
              if (!dqm_o[0]) bmem[key][7:0]  = dq_o[7:0];
              if (!dqm_o[1]) bmem[key][15:8] = dq_o[15:8];
              last_wr = cyc;
            end else begin
              rd_val = bmem.exists(key) ? bmem[key] : '0;
              rd_cd = CL;
            end
          end else chk(0, "R4", "unexpected column cmd", 0, 1);
        end
        default: ;
      endcase
    end
  end

  // ---------------- host side ----------------
  task automatic do_req(input bit w, input int bank, input int row, input int col,
                        input logic [15:0] d, input logic [1:0] b);
    acc_t e;
    int k;
    @(negedge clk);
    req = 1; we = w; addr = {2'(bank), 13'(row), 10'(col)}; wdata = d; be = b;
    while (!ready_o) @(negedge clk);
    e.w = w; e.bank = bank; e.row = row; e.col = col; e.d = d; e.be = b;
    exp_q.push_back(e);
    k = int'(addr);
    if (!hmem.exists(k)) hmem[k] = '0;
    if (w) begin
      if (b[0]) hmem[k][7:0]  = d[7:0];
      if (b[1]) hmem[k][15:8] = d[15:8];
    end else rd_exp.push_back(hmem[k]);
    @(negedge clk);
    req = 0;
    chk(ready_o === 1'b0, "R10", "ready after accept", 32'(ready_o), 0);
    chk({cs_n_o, ras_n_o, cas_n_o, we_n_o} === 4'b0011, "R10", "act after accept",
        32'({cs_n_o, ras_n_o, cas_n_o, we_n_o}), 3);
  endtask

  bit done = 0;

  initial begin
    logic [15:0] lf;
    int j;
    repeat (3) @(negedge clk);
    chk(cke_o === 1'b0, "R1", "cke in reset", 32'(cke_o), 0);
    chk(ready_o === 1'b0, "R1", "ready in reset", 32'(ready_o), 0);
    chk({cs_n_o, ras_n_o, cas_n_o, we_n_o} === 4'b0111, "R1", "cmd in reset",
        32'({cs_n_o, ras_n_o, cas_n_o, we_n_o}), 7);
    chk(dqm_o === 2'b11, "R1", "dqm in reset", 32'(dqm_o), 3);
    #2 rst_ni = 1;
    @(negedge clk);
    chk(cke_o === 1'b1, "R1", "cke after reset", 32'(cke_o), 1);
    while (!ready_o) @(negedge clk);
    chk(pre_seen && mrs_seen, "R2", "setup complete", 32'({pre_seen, mrs_seen}), 3);
    // corners
    do_req(1, 0, 0, 0, 16'haaaa, 2'b11);
    do_req(1, 3, 13'h1fff, 10'h3ff, 16'h5555, 2'b11);
    do_req(1, 1, 13'h0123, 10'h045, 16'h1234, 2'b11);
    do_req(1, 1, 13'h0123, 10'h045, 16'hffcd, 2'b01);
    do_req(1, 2, 13'h0abc, 10'h200, 16'h9876, 2'b11);
    do_req(1, 2, 13'h0abc, 10'h200, 16'h42ff, 2'b10);
    do_req(0, 0, 0, 0, '0, '0);
    do_req(0, 3, 13'h1fff, 10'h3ff, '0, '0);
    do_req(0, 1, 13'h0123, 10'h045, '0, '0);
    do_req(0, 2, 13'h0abc, 10'h200, '0, '0);
    do_req(0, 2, 13'h0555, 10'h111, '0, '0);
    // back-to-back mixed traffic across several refresh intervals
    lf = 16'hace1;
    for (int i = 0; i < 400; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      j = int'(lf[2:0]);
      do_req(lf[5], j & 3, (j * 1234 + 7) & 13'h1fff, (j * 97) & 10'h3ff, lf ^ 16'h3c3c, lf[9:8]);
    end
    repeat (30) @(negedge clk);
    chk(nref >= 3, "R7", "refreshes served under load", 32'(nref), 3);
    chk(exp_q.size() == 0, "R4", "accesses left unissued", 32'(exp_q.size()), 0);
    chk(rd_exp.size() == 0, "R9", "reads left unreturned", 32'(rd_exp.size()), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule